// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a byte-organized serial EEPROM on a two-wire bus (SCL clock, open-drain SDA). Both bus lines are resynchronized into a fast system clock. The block finds START and STOP conditions, matches a device-select byte, and acknowledges. It takes in a word address and supports page writes, current and random reads, and sequential reads. The array depth is set by parameter (256 to 2048 bytes). Depending on depth, the three bits that follow the fixed select prefix are compared against strap pins or used as the high memory address bits.

Written bytes go into a 16-byte page buffer. On STOP the buffer is committed to the array during a self-timed busy period. The busy period lasts a parameterized number of clocks, and the block stays silent on the bus until it ends. A write-protect input, sampled at the STOP, blocks the commit of any byte in the upper half of the array. SDA is modelled as an open-drain pull-down enable. The surrounding pad drives the line low whenever `sda_oe_o` is high.

The state machine has these states:
- `ST_IDLE`: waits for a START.
- `ST_DEV`: shifts in the select byte.
- `ST_DEV_ACK`: acknowledges the select byte.
- `ST_WADDR` and `ST_WADDR_ACK`: take in and acknowledge the word address.
- `ST_WDATA` and `ST_WDATA_ACK`: take in and acknowledge write data.
- `ST_RDATA`: drives a read byte.
- `ST_RACK`: samples the master's acknowledge.
- `ST_BUSY`: the commit period.

The transitions are:
- A START in any state except `ST_BUSY` goes to `ST_DEV`.
- A STOP goes to `ST_BUSY` if data bytes were buffered, and to `ST_IDLE` otherwise.
- `ST_DEV` goes to `ST_DEV_ACK` on a match, or to `ST_IDLE` on a mismatch, at the SCL fall after bit 8.
- `ST_DEV_ACK` goes to `ST_RDATA` for a read or `ST_WADDR` for a write.
- `ST_WADDR` goes to `ST_WADDR_ACK`, then to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate.
- `ST_RDATA` goes to `ST_RACK` after eight bits.
- `ST_RACK` goes back to `ST_RDATA` on a master ACK, or to `ST_IDLE` on a NACK.
- `ST_BUSY` goes to `ST_IDLE` when the commit timer expires.

Top module: `eep_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After reset, and after every STOP, bus bytes get no acknowledge until a START is seen. The block never pulls SDA low in the cycle after a STOP.
- R2: The select byte is sent MSB first. Bits 7..4 must be 1010. With 512 words (the default), bits 3 and 2 must equal strap pins 2 and 1. A select byte that does not match gets no ACK, and later bytes are ignored until the next START.
- R3: The select bits below the strap-compared ones carry memory address bits 8 and up. With 512 words, bit 1 is address bit 8, and strap pin 0 is not compared.
- R4: The block acknowledges by pulling SDA low during the ninth SCL pulse. It does this after a matching select byte, after the word-address byte, and after each write data byte.
- R5: During a write, the low 4 address bits count up and wrap within the 16-byte page, while the upper bits stay fixed. A 17th or later byte overwrites the entry that its wrapped offset points to.
- R6: A STOP after at least one data byte starts a busy period of WRITE_CLKS clocks. During that period select bytes get no ACK. A write that ends at the STOP with no data bytes (a dummy write) starts no busy period.
- R7: When the write-protect input is high at the STOP, bytes whose address has the top bit set are not committed, while lower-half bytes are. When the input is low, every address can be written.
- R8: In a read, the byte at the current address is driven MSB first, with one bit per SCL low phase, and SDA is released for the acknowledge bit. The address then advances by one after every byte and rolls over from the top of the array to 0.
- R9: After a master NACK the block stops driving SDA and ignores the bus until the next START.
- R10: A random read is a select-write plus a word-address byte, then a repeated START and a select-read. It returns the byte at that address.
- R11: After reset SDA is released and every array location reads 0xFF.
- R12: While SCL is high the block never changes its SDA drive, except in response to a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull SDA low (open-drain) |
| strap_i | input | 3 | Hard-wired select pins; only the top 11-ADDR_W bits are compared |
| wp_i | input | 1 | Write protect for the upper half of the array |

## Verification
The assertions assume that the bus lines only change while SCL is low, except for deliberate START and STOP conditions. They also assume that each SCL phase lasts many system clocks, longer than the resynchronizer and edge-detect delay. The assertions further assume that the master starts no transfer while the block is still driving a read bit. The stimulus tasks meet these assumptions. Every SDA change is placed a full quarter bit after an SCL fall, and every SCL phase spans several clocks. Random page writes use random addresses, lengths up to 18 bytes and write-protect levels. Each is followed by a full-page sequential read, and the results are compared with a bench model of page buffering and protection.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_BUSY
    } eep_state_e;

    localparam logic [3:0] SEL_PREFIX = 4'b1010;

endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // bus idles high, so the synchronizers reset to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int AW   = 9,
    parameter int PW   = 4,
    parameter int WCLK = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_we,
    input  logic [PW-1:0]     buf_idx,
    input  logic [7:0]        buf_din,
    input  logic              buf_clr,
    input  logic              commit,
    input  logic [AW-PW-1:0]  page,
    input  logic              wp,
    input  logic [AW-1:0]     rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);

    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PW;
    localparam int PGW   = AW - PW;
    localparam int CW    = $clog2(WCLK + 1);

    logic [7:0]      mem  [DEPTH];
    logic [7:0]      pbuf [PAGE];
    logic [PAGE-1:0] pvalid;
    logic [PGW-1:0]  cpage;
    logic            cwp;
    logic [CW-1:0]   cnt;
    logic [PW-1:0]   cidx;
    logic            mem_we;
    logic [AW-1:0]   mem_wa;

    // one buffered byte is moved per clock during the first PAGE busy cycles
    assign cidx   = cnt[PW-1:0];
    assign mem_we = busy && (cnt < CW'(PAGE)) && pvalid[cidx] && !(cwp && cpage[PGW-1]);
    assign mem_wa = {cpage, cidx};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            cpage  <= '0;
            cwp    <= 1'b0;
            pvalid <= '0;
        end else begin
            if (commit) begin
                busy  <= 1'b1;
                cnt   <= '0;
                cpage <= page;
                cwp   <= wp;
            end else if (busy) begin
                cnt <= cnt + CW'(1);
                if (cnt == CW'(WCLK - 1)) begin
                    busy   <= 1'b0;
                    pvalid <= '0;
                end
            end
            if (buf_clr) begin
                pvalid <= '0;
            end else if (buf_we) begin
                pvalid[buf_idx] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we) begin
            pbuf[buf_idx] <= buf_din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (mem_we) begin
            mem[mem_wa] <= pbuf[cidx];
        end
    end

    assign rd_data = mem[rd_addr];

    // R6: a commit request always opens a busy window
    p_commit_opens_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // R5: the page buffer is never touched while it is being committed
    p_no_fill_while_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we || buf_clr || commit) |-> !busy);

endmodule

// File: rtl/eep_slave.sv
module eep_slave
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_W      = 4,
    parameter int WRITE_CLKS  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);

    localparam int HI_BITS = ADDR_W - 8;
    localparam logic [2:0] PIN_MASK = 3'((7 << HI_BITS) & 7);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    eep_state_e        st, st_nx;
    logic [7:0]        shreg;
    logic [3:0]        bitcnt;
    logic [ADDR_W-1:0] addr;
    logic              is_read;
    logic              mack;
    logic              have_data;
    logic              byte_done;
    logic              sel_match;
    logic              buf_we, buf_clr, commit;
    logic [7:0]        rd_data;
    logic              store_busy;

    eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    eep_store #(.AW(ADDR_W), .PW(PAGE_W), .WCLK(WRITE_CLKS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .buf_we  (buf_we),
        .buf_idx (addr[PAGE_W-1:0]),
        .buf_din (shreg),
        .buf_clr (buf_clr),
        .commit  (commit),
        .page    (addr[ADDR_W-1:PAGE_W]),
        .wp      (wp_i),
        .rd_addr (addr),
        .rd_data (rd_data),
        .busy    (store_busy)
    );

    assign byte_done = (bitcnt == 4'd8);
    assign sel_match = (shreg[7:4] == SEL_PREFIX) && (((shreg[3:1] ^ strap_i) & PIN_MASK) == 3'b000);

    // next-state decision
    always_comb begin
        st_nx = st;
        if (st == ST_BUSY) begin
            if (!store_busy) st_nx = ST_IDLE;
        end else if (start_ev) begin
            st_nx = ST_DEV;
        end else if (stop_ev) begin
            st_nx = have_data ? ST_BUSY : ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:      st_nx = ST_IDLE;
                ST_DEV:       if (scl_fall && byte_done) st_nx = sel_match ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) st_nx = is_read ? ST_RDATA : ST_WADDR;
                ST_WADDR:     if (scl_fall && byte_done) st_nx = ST_WADDR_ACK;
                ST_WADDR_ACK: if (scl_fall) st_nx = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) st_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) st_nx = ST_WDATA;
                ST_RDATA:     if (scl_fall && bitcnt == 4'd7) st_nx = ST_RACK;
                ST_RACK:      if (scl_fall) st_nx = mack ? ST_RDATA : ST_IDLE;
                ST_BUSY:      st_nx = ST_BUSY;
                default:      st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            addr      <= '0;
            is_read   <= 1'b0;
            mack      <= 1'b0;
            have_data <= 1'b0;
        end else if (st != ST_BUSY && (start_ev || stop_ev)) begin
            bitcnt    <= '0;
            have_data <= 1'b0;
        end else begin
            unique case (st)
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && byte_done) begin
                        bitcnt <= '0;
                        if (st == ST_DEV && sel_match) begin
                            is_read <= shreg[0];
                            for (int i = 8; i < ADDR_W; i++) begin
                                addr[i] <= shreg[i-7];
                            end
                        end
                        if (st == ST_WADDR) begin
                            addr[7:0] <= shreg;
                        end
                        if (st == ST_WDATA) begin
                            addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
                            have_data        <= 1'b1;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall && is_read) begin
                        shreg  <= rd_data;
                        bitcnt <= '0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 4'd1;
                        if (bitcnt == 4'd7) addr <= addr + ADDR_W'(1);
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        mack <= ~sda_s;
                    end else if (scl_fall && mack) begin
                        shreg  <= rd_data;
                        bitcnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (st)
            ST_DEV_ACK, ST_WADDR_ACK, ST_WDATA_ACK: sda_oe_o = 1'b1;
            ST_RDATA:                               sda_oe_o = ~shreg[7];
            default:                                sda_oe_o = 1'b0;
        endcase
        buf_we  = (st == ST_WDATA) && scl_fall && byte_done && !start_ev && !stop_ev;
        buf_clr = (st != ST_BUSY) && start_ev;
        commit  = (st != ST_BUSY) && !start_ev && stop_ev && have_data;
    end

    // R6: the bus stays released for the whole commit window
    p_quiet_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        store_busy |-> !sda_oe_o);

    // R12: drive level only moves on SCL low or on a START/STOP
    p_hold_while_scl_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && !start_ev && !stop_ev) |=> $stable(sda_oe_o));

    // R1: a STOP always leaves the line released
    p_stop_releases_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe_o);

    // R2: a wrong prefix never earns an acknowledge
    p_bad_prefix_no_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_DEV && scl_fall && byte_done && shreg[7:4] != SEL_PREFIX) |=> !sda_oe_o);

endmodule

// File: tb/eep_slave_test.sv
`timescale 1ns/1ps
module eep_slave_test;

    localparam int AW    = 9;
    localparam int DEPTH = 1 << AW;
    localparam int WCLK  = 600;
    localparam int Q     = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_bus;
    int   total = 0;
    int   bad = 0;

    logic [7:0] model [DEPTH];
    logic [7:0] wbuf [32];

    always #2.5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    eep_slave #(.ADDR_W(AW), .WRITE_CLKS(WCLK)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .sda_oe_o (sda_oe),
        .strap_i  (STRAP),
        .wp_i     (wp)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] sel(input logic a8, input logic rd);
        return {4'b1010, STRAP[2], STRAP[1], a8, rd};
    endfunction

    task automatic do_start();
        scl = 1'b0; tick(Q);
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic do_stop();
        scl = 1'b0; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1; tick(2 * Q);
            scl = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1; tick(Q);
        acked = !sda_bus;
        tick(Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        logic s2;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b[i] = sda_bus;
            tick(Q);
            s2 = sda_bus;
            chk(s2 == b[i], "R12", "data moved while SCL high", int'(s2), int'(b[i]));
            scl = 1'b0; tick(Q);
        end
        sda_m = give_ack ? 1'b0 : 1'b1; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    // page write plus bench model of buffering, page wrap and protection
    task automatic page_write(input logic [AW-1:0] a, input int n, input string req);
        logic       ack;
        int         nack = 0;
        logic [7:0] pb [16];
        bit         pv [16];
        do_start();
        send_byte(sel(a[8], 1'b0), ack); if (!ack) nack++;
        send_byte(a[7:0], ack);          if (!ack) nack++;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);     if (!ack) nack++;
        end
        do_stop();
        chk(nack == 0, req, "missing write acks", nack, 0);
        for (int i = 0; i < 16; i++) pv[i] = 1'b0;
        for (int i = 0; i < n; i++) begin
            pb[(int'(a[3:0]) + i) % 16] = wbuf[i];
            pv[(int'(a[3:0]) + i) % 16] = 1'b1;
        end
        for (int i = 0; i < 16; i++) begin
            logic [AW-1:0] t;
            t = {a[AW-1:4], 4'(i)};
            if (pv[i] && !(wp && t[AW-1])) model[t] = pb[i];
        end
    endtask

    task automatic settle();
        tick(WCLK + 60);
    endtask

    task automatic rand_read(input logic [AW-1:0] a, input int n, input string req);
        logic       ack;
        logic [7:0] b;
        logic [AW-1:0] t;
        do_start();
        send_byte(sel(a[8], 1'b0), ack);
        chk(ack, "R4", "select ack", int'(ack), 1);
        send_byte(a[7:0], ack);
        chk(ack, "R4", "address ack", int'(ack), 1);
        do_start();
        send_byte(sel(a[8], 1'b1), ack);
        chk(ack, "R10", "read select ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i < n - 1);
            t = a + AW'(i);
            chk(b == model[t], req, "read data", int'(b), int'(model[t]));
        end
        do_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        void'($urandom(32'd4711));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        tick(10);
        rst_n = 1'b1;
        tick(10);

        // R11: released after reset
        chk(sda_bus == 1'b1 && sda_oe == 1'b0, "R11", "line after reset", int'(sda_oe), 0);

        // R1: a byte without START is ignored
        send_byte(sel(1'b0, 1'b0), ack);
        chk(!ack, "R1", "ack without START", int'(ack), 0);
        do_stop();

        // R11: erased content
        rand_read(9'h055, 2, "R11");

        // R2: wrong strap bit, wrong prefix, then no START
        do_start();
        send_byte({4'b1010, ~STRAP[2], STRAP[1], 1'b0, 1'b0}, ack);
        chk(!ack, "R2", "strap mismatch ack", int'(ack), 0);
        send_byte(sel(1'b0, 1'b0), ack);
        chk(!ack, "R2", "ack before new START", int'(ack), 0);
        do_start();
        send_byte({4'b1011, STRAP[2], STRAP[1], 1'b0, 1'b0}, ack);
        chk(!ack, "R2", "prefix mismatch ack", int'(ack), 0);
        do_stop();

        // R4 / R6 / R10: short write, busy poll, random read
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        page_write(9'h0F0, 3, "R4");
        do_start();
        send_byte(sel(1'b0, 1'b0), ack);
        chk(!ack, "R6", "ack while busy", int'(ack), 0);
        do_stop();
        settle();
        rand_read(9'h0F0, 3, "R10");

        // R5: wrap within page, and overflow beyond 16 bytes
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
        page_write(9'h03E, 4, "R5");
        settle();
        rand_read(9'h030, 16, "R5");
        for (int i = 0; i < 18; i++) wbuf[i] = 8'h40 + 8'(i);
        page_write(9'h040, 18, "R5");
        settle();
        rand_read(9'h040, 16, "R5");

        // R3: select bit 1 is address bit 8
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
        page_write(9'h1A0, 2, "R3");
        settle();
        wbuf[0] = 8'h0F; wbuf[1] = 8'hF0;
        page_write(9'h0A0, 2, "R3");
        settle();
        rand_read(9'h1A0, 2, "R3");
        rand_read(9'h0A0, 2, "R3");

        // R7: protection of the upper half only
        wp = 1'b1;
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        page_write(9'h1C0, 2, "R7");
        settle();
        page_write(9'h0C0, 2, "R7");
        settle();
        wp = 1'b0;
        rand_read(9'h1C0, 2, "R7");
        rand_read(9'h0C0, 2, "R7");
        wbuf[0] = 8'h99;
        page_write(9'h1C0, 1, "R7");
        settle();
        rand_read(9'h1C0, 1, "R7");

        // R8: rollover from the top address
        wbuf[0] = 8'hE1;
        page_write(9'h1FF, 1, "R8");
        settle();
        wbuf[0] = 8'hE2;
        page_write(9'h000, 1, "R8");
        settle();
        rand_read(9'h1FF, 3, "R8");

        // R9: line released after master NACK
        do_start();
        send_byte(sel(1'b0, 1'b0), ack);
        send_byte(8'h00, ack);
        do_start();
        send_byte(sel(1'b0, 1'b1), ack);
        recv_byte(b, 1'b0);
        chk(b == model[0], "R9", "byte before NACK", int'(b), int'(model[0]));
        tick(Q);
        scl = 1'b1; tick(Q);
        chk(sda_bus == 1'b1, "R9", "line after NACK", int'(sda_bus), 1);
        tick(Q);
        scl = 1'b0; tick(Q);
        do_stop();

        // R6: dummy write leaves no busy window
        do_start();
        send_byte(sel(1'b0, 1'b0), ack);
        send_byte(8'h10, ack);
        do_stop();
        do_start();
        send_byte(sel(1'b0, 1'b0), ack);
        chk(ack, "R6", "ack after dummy write", int'(ack), 1);
        do_stop();

        // R5 / R7: random page writes checked by full-page reads
        for (int k = 0; k < 4; k++) begin
            logic [AW-1:0] a;
            int n;
            a = AW'($urandom % DEPTH);
            n = 1 + int'($urandom % 18);
            wp = 1'(($urandom % 2));
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            page_write(a, n, "R5");
            settle();
            wp = 1'b0;
            rand_read({a[AW-1:4], 4'h0}, 16, "R7");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule